// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Port

This block lets an external host configure a data converter over three wires: a serial clock, an active-low select and one data line that carries traffic both ways. The host sends a 16-bit header, then data bytes. The header gives the transfer direction, a byte count and a 13-bit start address. On a write, the block stores each byte it receives into a 16-byte register file. On a read, the block takes over the data line and shifts the addressed bytes back to the host on that same line.

All three pins are sampled in a system clock that runs at least four times faster than the serial clock. The block finds the serial clock edges in that domain. It drives the shared line through a separate output-enable, so the pad tristate stays outside the block. When the select is released in the middle of a frame, the transfer is cut off. Any partial byte is lost, and the next frame starts from a clean header.

Top module: `cfg_spi3w`

## Requirements
- R1: A frame starts with a 16-bit header, sent most significant bit first. Bit 15 is the direction (1 = read, 0 = write). Bits 14:13 are the length code. Bits 12:0 are the start address.
- R2: Write data comes after the header, MSB first. The block samples it on rising serial clock edges and stores each complete byte at the current address.
- R3: Length codes 00, 01 and 10 transfer exactly 1, 2 and 3 bytes. Any bytes clocked after that count have no effect, and the data output stays disabled for them.
- R4: Length code 11 keeps transferring bytes until the select goes high.
- R5: After each byte the current address goes down by one, wrapping modulo 2^13.
- R6: On a read, the output enable turns on after the first falling serial clock edge that follows the header. Each falling edge then drives the next bit, MSB first, and the bit holds until the next falling edge.
- R7: On a read with a fixed length, the output enable turns off after the rising edge that samples the last bit. A write frame never turns the output enable on.
- R8: While the select is high, serial clock and data activity changes no register, and the output enable stays off.
- R9: Raising the select in the middle of a frame discards the partial byte and the header state. The output enable turns off, and the next frame decodes normally.
- R10: Only addresses 0 to 15 are mapped. A read from any other address returns 0x00, and a write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host |
| sel_n | input | 1 | Active-low frame select |
| dat_i | input | 1 | Data line as seen at the pad input |
| dat_o | output | 1 | Data value driven onto the line during reads |
| dat_oe | output | 1 | Enable for the data line driver |

## Verification
The hardest case to reach is the turn of the shared line at a byte boundary of a streaming read. The output enable has to stay on while the address steps down, and it must cross from mapped registers into the unmapped top of the address space. The bench reaches this case with an unbounded read that starts at address 3 and runs for five bytes. The fifth byte wraps to address 0x1FFF and must come back as zero. Aborts are forced by releasing the select after a few bits of a write and of a read. The bench then reads the target registers back to show that nothing leaked through.

// File: rtl/cfg_spi3w_pkg.sv
package cfg_spi3w_pkg;
  localparam int HDR_BITS = 16;
  typedef enum logic [1:0] {PH_HDR, PH_DATA, PH_DONE} phase_t;
endpackage

// File: rtl/cfg_spi3w_sync.sv
module cfg_spi3w_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] sync,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {(STAGES+1){RST_VAL[g]}};
      else     chain <= {chain[STAGES-1:0], pin[g]};
    end
    assign sync[g] = chain[STAGES-1];
    assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
    assign fall[g] = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/cfg_spi3w_regs.sv
module cfg_spi3w_regs #(
  parameter int DEPTH = 16,
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = $clog2(DEPTH);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr[IDX_W-1:0]] <= wdata;
  end

  assign rdata = (raddr < ADDR_W'(DEPTH)) ? mem[raddr[IDX_W-1:0]] : '0;

  // R10: the controller never issues a write to an unmapped address
  a_r10_mapped_write: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr < ADDR_W'(DEPTH)));
endmodule

// File: rtl/cfg_spi3w_frame.sv
module cfg_spi3w_frame
  import cfg_spi3w_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              din,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              dout,
  output logic              dout_oe
);
  localparam int CNT_W = $clog2(HDR_BITS);
  localparam int BIT_W = $clog2(DATA_W);

  phase_t              phase;
  logic [CNT_W-1:0]    hdr_cnt;
  logic [HDR_BITS-2:0] hdr_sr;
  logic                is_read;
  logic [1:0]          len;
  logic [1:0]          byte_cnt;
  logic [ADDR_W-1:0]   addr;
  logic [BIT_W-1:0]    bit_idx;
  logic [DATA_W-2:0]   byte_sr;
  logic                last_byte;

  assign rd_addr   = addr;
  assign last_byte = (len != 2'b11) && (byte_cnt == len);

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      phase    <= PH_HDR;
      hdr_cnt  <= '0;
      bit_idx  <= '0;
      byte_cnt <= '0;
      dout_oe  <= 1'b0;
      wr_en    <= 1'b0;
      if (rst) begin
        hdr_sr  <= '0;
        is_read <= 1'b0;
        len     <= '0;
        addr    <= '0;
        byte_sr <= '0;
        wr_addr <= '0;
        wr_data <= '0;
        dout    <= 1'b0;
      end
    end else begin
      wr_en <= 1'b0;
      if (sck_rise) begin
        case (phase)
          PH_HDR: begin
            hdr_cnt <= hdr_cnt + 1'b1;
            hdr_sr  <= {hdr_sr[HDR_BITS-3:0], din};
            if (hdr_cnt == CNT_W'(HDR_BITS-1)) begin
              is_read <= hdr_sr[HDR_BITS-2];
              len     <= hdr_sr[HDR_BITS-3:HDR_BITS-4];
              addr    <= {hdr_sr[ADDR_W-2:0], din};
              bit_idx <= '0;
              phase   <= PH_DATA;
            end
          end
          PH_DATA: begin
            bit_idx <= bit_idx + 1'b1;
            byte_sr <= {byte_sr[DATA_W-3:0], din};
            if (bit_idx == BIT_W'(DATA_W-1)) begin
              if (!is_read) begin
                wr_en   <= (addr < ADDR_W'(DEPTH));
                wr_addr <= addr;
                wr_data <= {byte_sr, din};
              end
              addr     <= addr - 1'b1;
              byte_cnt <= byte_cnt + 1'b1;
              if (last_byte) begin
                phase   <= PH_DONE;
                dout_oe <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end else if (sck_fall && phase == PH_DATA && is_read) begin
        dout_oe <= 1'b1;
        dout    <= rd_data[BIT_W'(DATA_W-1) - bit_idx];
      end
    end
  end

  // R6: the driver turns on only in response to a falling serial edge
  a_r6_oe_on_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_oe) |-> $past(sck_fall));
  // R6: the driven bit holds between falling edges
  a_r6_bit_hold: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && $past(dout_oe) && !$past(sck_fall)) |-> $stable(dout));
  // R7, R9: the driver turns off on a rising edge or on select release
  a_r7_oe_off: assert property (@(posedge clk) disable iff (rst)
    $fell(dout_oe) |-> ($past(sck_rise) || $past(!cs_act)));
  // R8: an idle select keeps the line released and the registers untouched
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (!dout_oe && !wr_en));
  // R2: stores happen only just after a rising serial edge
  a_r2_write_on_rise: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(sck_rise));
endmodule

// File: rtl/cfg_spi3w.sv
module cfg_spi3w #(
  parameter int DEPTH = 16,
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic sel_n,
  input  logic dat_i,
  output logic dat_o,
  output logic dat_oe
);
  logic [2:0] s_sync, s_rise, s_fall;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  cfg_spi3w_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .pin({dat_i, sel_n, ser_clk}),
    .sync(s_sync), .rise(s_rise), .fall(s_fall)
  );

  cfg_spi3w_frame #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .cs_act(~s_sync[1]),
    .sck_rise(s_rise[0]), .sck_fall(s_fall[0]), .din(s_sync[2]),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(dat_o), .dout_oe(dat_oe)
  );

  cfg_spi3w_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: tb/tb_cfg_spi3w.sv
module tb_cfg_spi3w;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 0, rst = 1, ser_clk = 0, sel_n = 1, drv = 0;
  logic dat_o, dat_oe, dat_i;
  int checks = 0, errors = 0;
  logic [7:0] model [16];
  logic wr_frame = 0;
  int wr_oe_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign dat_i = dat_oe ? dat_o : drv;

  cfg_spi3w dut (.clk(clk), .rst(rst), .ser_clk(ser_clk), .sel_n(sel_n),
                 .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe));

  always @(negedge clk) if ((wr_frame || sel_n) && dat_oe) wr_oe_seen++;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expv(input int a);
    return (a >= 0 && a < 16) ? model[a] : 8'h00;
  endfunction

  task automatic sbit(input logic b, output logic got, output logic oe);
    @(negedge clk); ser_clk = 0; drv = b;
    repeat (HALF) @(negedge clk);
    got = dat_o; oe = dat_oe;
    ser_clk = 1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic start();
    @(negedge clk); sel_n = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic stop();
    @(negedge clk); ser_clk = 0;
    repeat (HALF) @(negedge clk);
    sel_n = 1; wr_frame = 0;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic header(input logic rd, input logic [1:0] ln, input logic [12:0] a);
    logic [15:0] h; logic g, o;
    h = {rd, ln, a};
    wr_frame = !rd;
    for (int i = 15; i >= 0; i--) sbit(h[i], g, o);
  endtask

  task automatic wbyte(input logic [7:0] v);
    logic g, o;
    for (int i = 7; i >= 0; i--) sbit(v[i], g, o);
  endtask

  task automatic rbyte(input logic [7:0] e, input string req);
    logic [7:0] v; logic g, o, oe_all;
    oe_all = 1;
    for (int i = 7; i >= 0; i--) begin
      sbit(1'b0, g, o);
      v[i] = g; oe_all &= o;
    end
    check(oe_all, {req, " oe during read"}, oe_all, 1);
    check(v == e, req, v, e);
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] v);
    start(); header(0, 2'b00, a); wbyte(v); stop();
    if (a < 16) model[a] = v;
  endtask

  task automatic rd1(input logic [12:0] a, input string req);
    start(); header(1, 2'b00, a); rbyte(expv(a), req);
    check(!dat_oe, "R7 release after last bit", dat_oe, 0);
    stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic g, o;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (5) @(negedge clk);
    check(!dat_oe, "R8 reset oe", dat_oe, 0);

    // R1 R2 R6: single-byte write and read of every register
    for (int i = 0; i < 16; i++) wr1(13'(i), 8'((i*37 + 11) & 255));
    for (int i = 0; i < 16; i++) rd1(13'(i), "R1 R2 R6 single read");

    // R3 R5: three-byte and two-byte writes with descending address
    start(); header(0, 2'b10, 13'd15);
    wbyte(8'hA1); wbyte(8'hB2); wbyte(8'hC3); stop();
    model[15] = 8'hA1; model[14] = 8'hB2; model[13] = 8'hC3;
    start(); header(0, 2'b01, 13'd8);
    wbyte(8'h5E); wbyte(8'h6F); stop();
    model[8] = 8'h5E; model[7] = 8'h6F;
    start(); header(1, 2'b10, 13'd15);
    rbyte(model[15], "R3 R5 burst0"); rbyte(model[14], "R5 burst1");
    rbyte(model[13], "R5 burst2");
    check(!dat_oe, "R7 release after third byte", dat_oe, 0);
    stop();
    rd1(13'd8, "R5 two-byte"); rd1(13'd7, "R5 two-byte second");

    // R3: bytes beyond a one-byte length are ignored
    start(); header(0, 2'b00, 13'd2);
    wbyte(8'h11); wbyte(8'h22); wbyte(8'h33); stop();
    model[2] = 8'h11;
    rd1(13'd2, "R3 first byte kept"); rd1(13'd1, "R3 extra ignored");
    rd1(13'd0, "R3 extra ignored");
    start(); header(1, 2'b00, 13'd4); rbyte(model[4], "R3 read len1");
    o = 0;
    for (int i = 0; i < 8; i++) begin sbit(1'b0, g, g); o |= dat_oe; end
    check(!o, "R3 no drive past length", o, 0);
    stop();

    // R4: streaming write and streaming read crossing into unmapped space
    start(); header(0, 2'b11, 13'd6);
    for (int i = 0; i < 5; i++) begin
      wbyte(8'(8'h90 + i)); model[6-i] = 8'(8'h90 + i);
    end
    stop();
    start(); header(1, 2'b11, 13'd3);
    for (int i = 0; i < 4; i++) rbyte(model[3-i], "R4 stream read");
    rbyte(8'h00, "R10 wrap to 0x1FFF reads zero");
    check(dat_oe, "R4 stream keeps driving", dat_oe, 1);
    stop();

    // R10: unmapped writes do not alias
    wr1(13'h0010, 8'hEE); wr1(13'h1FFF, 8'hDD); wr1(13'h1004, 8'hCC);
    rd1(13'h0000, "R10 no alias 0"); rd1(13'h000F, "R10 no alias F");
    rd1(13'h0004, "R10 no alias 4"); rd1(13'h0010, "R10 unmapped read");

    // R9: abort of a write and of a read
    start(); header(0, 2'b00, 13'd5);
    for (int i = 0; i < 4; i++) sbit(1'b1, g, o);
    stop();
    rd1(13'd5, "R9 aborted write discarded");
    start(); header(1, 2'b00, 13'd9);
    for (int i = 0; i < 3; i++) sbit(1'b0, g, o);
    @(negedge clk); sel_n = 1;
    repeat (4) @(negedge clk);
    check(!dat_oe, "R9 abort releases line", dat_oe, 0);
    repeat (2*HALF) @(negedge clk);
    rd1(13'd9, "R9 next frame decodes");

    // R8: activity with the select high is ignored
    wr_oe_seen = 0;
    begin
      logic [23:0] f;
      f = {1'b0, 2'b00, 13'd7, 8'h3C};
      for (int i = 23; i >= 0; i--) sbit(f[i], g, o);
      @(negedge clk); ser_clk = 0;
      repeat (2*HALF) @(negedge clk);
    end
    check(wr_oe_seen == 0, "R8 R7 no drive when idle or writing", wr_oe_seen, 0);
    rd1(13'd7, "R8 idle write ignored");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule